// File: doc/BRIEF.md
# Four-Lane Hamming-Corrected Link Aligner

This block sits at the receiving end of four parallel serial links. The links have already been deserialized. On every link clock, each lane delivers a 24-bit codeword. The codeword holds 19 payload bits protected by 5 check bits. The block decodes every codeword as it arrives. It repairs any single flipped bit and flags words it cannot repair. The decoded words enter a small dual-clock FIFO per lane.

On the read side, the FIFOs are drained in a faster pipeline clock domain. The link clock is three times the crossing rate and the pipeline clock is four times the crossing rate. Each lane marks the first word of a frame. A bonding controller throws away words until all four lanes hold a marked word at their head. It then pops the four lanes together, so that every output beat carries the same slot from all four links.

A status output shows whether the lanes are bonded. A per-lane sticky flag records uncorrectable words. A FIFO that overflows drops the bond, and the bond cannot return until reset.

Top module: `lane_aligner`

## Requirements
- R1: Codeword bit position p (1..24) is `laneWord[24*lane + p-1]`. Positions 1, 2, 4, 8 and 16 hold check bits. The other 19 positions hold payload bits 0..18 in ascending order, so payload bit 0 is at position 3 and payload bit 18 at position 24. A word whose syndrome (XOR of the positions of all set bits) is zero passes unchanged.
- R2: A word with syndrome 1..24 has that position inverted before payload extraction. The output beat that carries it sets the lane's bit in `outCorr`.
- R3: A word with syndrome 25..31 is passed without repair and with its `outCorr` bit clear. When such a word leaves the lane FIFO, the lane's `laneErr` bit sets and stays set until reset.
- R4: While unbonded, each lane discards words without a marker and holds its first marked word. `locked` rises once all four FIFO heads are marked words.
- R5: While bonded, a beat is produced only when all four lanes hold a word. Lane i's payload appears in `outData[19*i +: 19]`, slots appear in arrival order, and no slot is lost or repeated.
- R6: While bonded, if the four heads disagree on the marker, `locked` falls, no beat is produced in that cycle, and the R4 search restarts.
- R7: A write into a full lane FIFO is dropped and makes `locked` fall. `locked` then stays low until reset, even when traffic is correct.
- R8: While either reset is held, and after it is released, `locked`, `outValid` and `laneErr` are zero and the FIFOs are empty.
- R9: While bonded, a beat leaves within 12 pipeline-clock periods of the link-clock edge that wrote its last lane word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| linkClk | input | 1 | Link clock (3x crossing rate) |
| linkRst | input | 1 | Synchronous reset, link domain |
| laneWord | input | 96 | Four 24-bit codewords, lane 0 in the low bits |
| laneValid | input | 4 | Per-lane word valid |
| laneMark | input | 4 | Per-lane frame-start marker |
| pipeClk | input | 1 | Pipeline clock (4x crossing rate) |
| pipeRst | input | 1 | Synchronous reset, pipeline domain |
| outValid | output | 1 | Aligned beat present |
| outData | output | 76 | Four 19-bit payloads, lane 0 in the low bits |
| outCorr | output | 4 | Per-lane single-bit repair flag for this beat |
| laneErr | output | 4 | Sticky per-lane uncorrectable flag |
| locked | output | 1 | Lanes bonded |

## Verification
Repair and detection can hit the same beat on different lanes. The bench provokes this by flipping one bit of lane 1's word and two bits of lane 2's word (positions 1 and 24, syndrome 25) in the same slot. The scoreboard then expects that beat to carry lane 1's clean payload with its repair flag set, and lane 2's payload with bit 18 inverted and no repair flag. After the beat, `laneErr` must read 4'b0100.

A second collision occurs when a marker disagreement arrives while the lanes are bonded. The bench inserts a stray word ahead of lane 3's next frame. It checks that `locked` falls, and that the frame following the stray word still comes out fully aligned.

// File: rtl/lane_aligner_pkg.sv
package lane_aligner_pkg;
  localparam int LANES = 4;
  localparam int CW = 24;
  localparam int DW = 19;
  localparam int SW = 5;
  localparam int IW = $clog2(CW);

  typedef struct packed {
    logic          unc;
    logic          corr;
    logic          mark;
    logic [DW-1:0] data;
  } entry_t;

  typedef struct packed {
    logic [LANES-1:0] pop;
    logic             capture;
  } strobe_t;

  typedef struct packed {
    logic [LANES-1:0] nonEmpty;
    logic [LANES-1:0] headMark;
    logic [LANES-1:0] headUnc;
    logic             ovf;
  } status_t;

  function automatic entry_t decodeWord(input logic [CW-1:0] w, input logic mark);
    entry_t e;
    logic [SW-1:0] syn;
    logic [CW-1:0] fixed;
    int k;
    syn = '0;
    for (int p = 1; p <= CW; p++) if (w[IW'(p-1)]) syn ^= SW'(p);
    fixed  = w;
    e.corr = 1'b0;
    e.unc  = 1'b0;
    e.mark = mark;
    e.data = '0;
    if (syn != '0) begin
      if (int'(syn) <= CW) begin
        e.corr = 1'b1;
        for (int p = 1; p <= CW; p++)
          if (int'(syn) == p) fixed[IW'(p-1)] = ~fixed[IW'(p-1)];
      end else begin
        e.unc = 1'b1;
      end
    end
    k = 0;
    for (int p = 1; p <= CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        e.data[IW'(k)] = fixed[IW'(p-1)];
        k++;
      end
    end
    return e;
  endfunction
endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 22
) (
  input  logic         wClk,
  input  logic         wRst,
  input  logic         wEn,
  input  logic [W-1:0] wData,
  output logic         ovf,
  input  logic         rClk,
  input  logic         rRst,
  input  logic         rEn,
  output logic [W-1:0] rData,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0] wBin, wGray, wBinNext, rSync1, rSync2;
  logic [AW:0] rBin, rGray, rBinNext, wSync1, wSync2;
  logic full, doWrite, doRead;

  assign wBinNext = wBin + 1'b1;
  assign full     = (wGray == {~rSync2[AW:AW-1], rSync2[AW-2:0]});
  assign doWrite  = wEn && !full;

  always_ff @(posedge wClk) begin
    if (wRst) begin
      wBin <= '0; wGray <= '0; rSync1 <= '0; rSync2 <= '0; ovf <= 1'b0;
    end else begin
      rSync1 <= rGray;
      rSync2 <= rSync1;
      ovf    <= wEn && full;
      if (doWrite) begin
        wBin  <= wBinNext;
        wGray <= wBinNext ^ (wBinNext >> 1);
      end
    end
  end

  always_ff @(posedge wClk) begin
    if (doWrite) mem[wBin[AW-1:0]] <= wData;
  end

  assign rBinNext = rBin + 1'b1;
  assign empty    = (rGray == wSync2);
  assign doRead   = rEn && !empty;
  assign rData    = mem[rBin[AW-1:0]];

  always_ff @(posedge rClk) begin
    if (rRst) begin
      rBin <= '0; rGray <= '0; wSync1 <= '0; wSync2 <= '0;
    end else begin
      wSync1 <= wGray;
      wSync2 <= wSync1;
      if (doRead) begin
        rBin  <= rBinNext;
        rGray <= rBinNext ^ (rBinNext >> 1);
      end
    end
  end

  // A write into a full FIFO must not move the write pointer.
  assert_full_blocks_write_R7: assert property (@(posedge wClk) disable iff (wRst)
    (wEn && full) |=> $stable(wBin));
endmodule

// File: rtl/lane_datapath.sv
module lane_datapath
  import lane_aligner_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                linkClk,
  input  logic                linkRst,
  input  logic [LANES*CW-1:0] laneWord,
  input  logic [LANES-1:0]    laneValid,
  input  logic [LANES-1:0]    laneMark,
  input  logic                pipeClk,
  input  logic                pipeRst,
  input  strobe_t             strobe,
  output status_t             status,
  output logic                outValid,
  output logic [LANES*DW-1:0] outData,
  output logic [LANES-1:0]    outCorr
);
  logic [LANES-1:0]    ovfPulse, ovfSticky, notEmpty, hMark, hUnc, hCorr;
  logic [LANES*DW-1:0] hData;
  logic ovfMeta, ovfSeen;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    entry_t wEntry, rEntry;
    logic   isEmpty;
    assign wEntry = decodeWord(laneWord[g*CW +: CW], laneMark[g]);
    lane_fifo #(.DEPTH(DEPTH), .W($bits(entry_t))) fifoI (
      .wClk(linkClk), .wRst(linkRst), .wEn(laneValid[g]), .wData(wEntry),
      .ovf(ovfPulse[g]),
      .rClk(pipeClk), .rRst(pipeRst), .rEn(strobe.pop[g]), .rData(rEntry),
      .empty(isEmpty)
    );
    assign notEmpty[g]        = !isEmpty;
    assign hMark[g]           = rEntry.mark;
    assign hUnc[g]            = rEntry.unc;
    assign hCorr[g]           = rEntry.corr;
    assign hData[g*DW +: DW]  = rEntry.data;
  end

  always_ff @(posedge linkClk) begin
    if (linkRst) ovfSticky <= '0;
    else         ovfSticky <= ovfSticky | ovfPulse;
  end

  always_ff @(posedge pipeClk) begin
    if (pipeRst) begin
      ovfMeta <= 1'b0; ovfSeen <= 1'b0;
    end else begin
      ovfMeta <= |ovfSticky;
      ovfSeen <= ovfMeta;
    end
  end

  assign status = '{nonEmpty: notEmpty, headMark: hMark, headUnc: hUnc, ovf: ovfSeen};

  always_ff @(posedge pipeClk) begin
    if (pipeRst) begin
      outValid <= 1'b0; outData <= '0; outCorr <= '0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        outData <= hData;
        outCorr <= hCorr;
      end
    end
  end

  // The controller must never pop a lane whose FIFO is empty.
  assert_no_empty_pop_R5: assert property (@(posedge pipeClk) disable iff (pipeRst)
    (strobe.pop & ~notEmpty) == '0);
endmodule

// File: rtl/lane_bond_ctrl.sv
module lane_bond_ctrl
  import lane_aligner_pkg::*;
(
  input  logic             pipeClk,
  input  logic             pipeRst,
  input  status_t          status,
  output strobe_t          strobe,
  output logic             locked,
  output logic [LANES-1:0] laneErr
);
  typedef enum logic {SEARCH, BONDED} bondState_t;
  bondState_t state, stateNext;
  logic allReady, allMark, anyMark;

  assign allReady = &status.nonEmpty;
  assign allMark  = &status.headMark;
  assign anyMark  = |status.headMark;

  always_comb begin
    stateNext      = state;
    strobe.pop     = '0;
    strobe.capture = 1'b0;
    case (state)
      SEARCH: begin
        strobe.pop = status.nonEmpty & ~status.headMark;
        if (allReady && allMark && !status.ovf) stateNext = BONDED;
      end
      BONDED: begin
        if (status.ovf) begin
          stateNext = SEARCH;
        end else if (allReady) begin
          if (anyMark && !allMark) begin
            stateNext = SEARCH;
          end else begin
            strobe.pop     = '1;
            strobe.capture = 1'b1;
          end
        end
      end
      default: stateNext = SEARCH;
    endcase
  end

  always_ff @(posedge pipeClk) begin
    if (pipeRst) begin
      state   <= SEARCH;
      laneErr <= '0;
    end else begin
      state   <= stateNext;
      laneErr <= laneErr | (strobe.pop & status.headUnc);
    end
  end

  assign locked = (state == BONDED);

  assert_ovf_drops_lock_R7: assert property (@(posedge pipeClk) disable iff (pipeRst)
    status.ovf |=> !locked);
  assert_err_sticky_R3: assert property (@(posedge pipeClk) disable iff (pipeRst)
    1'b1 |=> ((laneErr & $past(laneErr)) == $past(laneErr)));
  assert_lock_needs_marks_R4: assert property (@(posedge pipeClk) disable iff (pipeRst)
    $rose(locked) |-> $past(allReady && allMark));
  assert_mismatch_unlocks_R6: assert property (@(posedge pipeClk) disable iff (pipeRst)
    (locked && allReady && anyMark && !allMark) |=> !locked);
endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
  import lane_aligner_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                linkClk,
  input  logic                linkRst,
  input  logic [LANES*CW-1:0] laneWord,
  input  logic [LANES-1:0]    laneValid,
  input  logic [LANES-1:0]    laneMark,
  input  logic                pipeClk,
  input  logic                pipeRst,
  output logic                outValid,
  output logic [LANES*DW-1:0] outData,
  output logic [LANES-1:0]    outCorr,
  output logic [LANES-1:0]    laneErr,
  output logic                locked
);
  strobe_t strobe;
  status_t status;

  lane_datapath #(.DEPTH(FIFO_DEPTH)) dataI (
    .linkClk(linkClk), .linkRst(linkRst), .laneWord(laneWord),
    .laneValid(laneValid), .laneMark(laneMark),
    .pipeClk(pipeClk), .pipeRst(pipeRst), .strobe(strobe), .status(status),
    .outValid(outValid), .outData(outData), .outCorr(outCorr)
  );

  lane_bond_ctrl ctrlI (
    .pipeClk(pipeClk), .pipeRst(pipeRst), .status(status),
    .strobe(strobe), .locked(locked), .laneErr(laneErr)
  );
endmodule

// File: tb/lane_aligner_tb_top.sv
module lane_aligner_tb_top;
  localparam time LINK_PERIOD = 8ns;
  localparam time PIPE_PERIOD = 6ns;

  logic linkClk = 1'b0, pipeClk = 1'b0;
  logic linkRst = 1'b1, pipeRst = 1'b1;
  logic [95:0] laneWord = '0;
  logic [3:0]  laneValid = '0, laneMark = '0;
  logic        outValid, locked;
  logic [75:0] outData;
  logic [3:0]  outCorr, laneErr;

  always #(LINK_PERIOD/2) linkClk = ~linkClk;
  always #(PIPE_PERIOD/2) pipeClk = ~pipeClk;

  lane_aligner dut_i (
    .linkClk(linkClk), .linkRst(linkRst), .laneWord(laneWord),
    .laneValid(laneValid), .laneMark(laneMark),
    .pipeClk(pipeClk), .pipeRst(pipeRst), .outValid(outValid),
    .outData(outData), .outCorr(outCorr), .laneErr(laneErr), .locked(locked)
  );

  typedef struct {
    logic [75:0] data;
    logic [3:0]  corr;
    time         t;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  int base = 0;
  int skew [4] = '{0, 0, 0, 0};
  int injIdx = -1;
  logic [23:0] injMask [4] = '{24'h0, 24'h0, 24'h0, 24'h0};
  logic sbOn = 1'b0, sawDrop = 1'b0, done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1 code layout: check bits at powers of two, payload ascending elsewhere.
  function automatic logic [23:0] enc(input logic [18:0] d);
    logic [23:0] w;
    int k;
    w = '0;
    k = 0;
    for (int p = 1; p <= 24; p++) begin
      if ((p & (p - 1)) != 0) begin
        w[5'(p-1)] = d[5'(k)];
        k++;
      end
    end
    for (int c = 0; c < 5; c++) begin
      logic par;
      par = 1'b0;
      for (int p = 1; p <= 24; p++)
        if (((p & (1 << c)) != 0) && ((p & (p - 1)) != 0)) par ^= w[5'(p-1)];
      w[5'((1 << c) - 1)] = par;
    end
    return w;
  endfunction

  function automatic logic [18:0] dataOf(input int lane, input int idx);
    return 19'(base * 7919 + idx * 37 + lane * 1021 + 5);
  endfunction

  task automatic sendFrames(input int nFrames);
    int n, mx;
    exp_t e;
    n = nFrames * 3;
    mx = 0;
    for (int l = 0; l < 4; l++) if (skew[l] > mx) mx = skew[l];
    for (int c = 0; c < n + mx; c++) begin
      int idxm;
      @(negedge linkClk);
      for (int l = 0; l < 4; l++) begin
        int idx;
        logic [23:0] w;
        idx = c - skew[l];
        if (idx < 0) begin
          laneWord[l*24 +: 24] = enc(19'h5A5A5 ^ 19'(c));
          laneValid[l] = 1'b1; laneMark[l] = 1'b0;
        end else if (idx >= n) begin
          laneValid[l] = 1'b0; laneMark[l] = 1'b0;
        end else begin
          w = enc(dataOf(l, idx));
          if (idx == injIdx) w ^= injMask[l];
          laneWord[l*24 +: 24] = w;
          laneValid[l] = 1'b1;
          laneMark[l] = (idx % 3 == 0);
        end
      end
      idxm = c - mx;
      if (sbOn && idxm >= 0 && idxm < n) begin
        for (int l = 0; l < 4; l++) begin
          logic [23:0] m;
          logic [18:0] d;
          m = (idxm == injIdx) ? injMask[l] : 24'h0;
          d = dataOf(l, idxm);
          e.corr[l] = ($countones(m) == 1);          // R2 expectation
          if ($countones(m) == 2) d ^= 19'h40000;     // R3: positions 1 and 24 hit, payload bit 18 left flipped
          e.data[l*19 +: 19] = d;
        end
        e.t = $time + LINK_PERIOD/2;
        q.push_back(e);
      end
    end
    @(negedge linkClk);
    laneValid = '0; laneMark = '0;
  endtask

  task automatic drain();
    repeat (40) @(negedge pipeClk);
    check(q.size() == 0, "R5 all slots delivered", 80'(q.size()), 80'(0));
  endtask

  // Scoreboard monitor
  always @(negedge pipeClk) begin
    if (sbOn && outValid && !done) begin
      if (q.size() == 0) begin
        check(1'b0, "R5 unexpected beat", 80'(outData), 80'(0));
      end else begin
        exp_t e;
        e = q.pop_front();
        check(outData == e.data, "R1/R5 payload", 80'(outData), 80'(e.data));
        check(outCorr == e.corr, "R2 repair flags", 80'(outCorr), 80'(e.corr));
        check(($time - e.t) <= 12 * PIPE_PERIOD, "R9 latency",
              80'($time - e.t), 80'(12 * PIPE_PERIOD));
      end
    end
    if (!locked) sawDrop = 1'b1;
  end

  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(negedge pipeClk);
    check(1'b0, "watchdog", 80'(0), 80'(1));
    finishRun();
  end

  task automatic doReset();
    @(negedge pipeClk);
    linkRst = 1'b1; pipeRst = 1'b1;
    repeat (6) @(negedge pipeClk);
    check(locked == 1'b0 && outValid == 1'b0 && laneErr == 4'b0, "R8 during reset",
          80'({locked, outValid, laneErr}), 80'(0));
    repeat (6) @(negedge pipeClk);
    @(negedge linkClk);
    linkRst = 1'b0; pipeRst = 1'b0;
    repeat (4) @(negedge pipeClk);
    check(locked == 1'b0 && outValid == 1'b0 && laneErr == 4'b0, "R8 after reset",
          80'({locked, outValid, laneErr}), 80'(0));
  endtask

  initial begin
    doReset();

    // Phase 1 (R4, R1, R5): skewed lanes carrying leading junk, clean codes
    sbOn = 1'b1;
    base = 1;
    skew = '{0, 1, 2, 3};
    sendFrames(4);
    drain();
    check(locked == 1'b1, "R4 bonded after markers", 80'(locked), 80'(1));

    // Phase 2 (R2, R3): repair and detection in the same beat, plus a check-bit flip
    base = 2;
    skew = '{0, 0, 0, 0};
    injIdx = 4;
    injMask = '{24'h0, 24'h000040, 24'h800001, 24'h0};
    sendFrames(3);
    drain();
    check(laneErr == 4'b0100, "R3 sticky error set", 80'(laneErr), 80'(4'b0100));
    injIdx = 5;
    injMask = '{24'h000008, 24'h0, 24'h0, 24'h800000};
    sendFrames(3);
    drain();
    injIdx = -1;

    // Phase 3 (R6): stray unmarked word ahead of lane 3's frame
    base = 3;
    sawDrop = 1'b0;
    skew = '{0, 0, 0, 1};
    sendFrames(3);
    drain();
    check(sawDrop == 1'b1, "R6 lock fell on marker mismatch", 80'(sawDrop), 80'(1));
    check(locked == 1'b1, "R6 rebonded on next marker", 80'(locked), 80'(1));
    check(laneErr == 4'b0100, "R3 error still held", 80'(laneErr), 80'(4'b0100));

    // Phase 4 (R7): lane 0 alone overfills its FIFO
    sbOn = 1'b0;
    for (int i = 0; i < 24; i++) begin
      @(negedge linkClk);
      laneWord[23:0] = enc(19'(i));
      laneValid = 4'b0001;
      laneMark = (i % 3 == 0) ? 4'b0001 : 4'b0000;
    end
    @(negedge linkClk);
    laneValid = '0; laneMark = '0;
    repeat (10) @(negedge pipeClk);
    check(locked == 1'b0, "R7 overflow drops lock", 80'(locked), 80'(0));
    base = 4;
    skew = '{0, 0, 0, 0};
    sendFrames(4);
    repeat (40) @(negedge pipeClk);
    check(locked == 1'b0, "R7 lock held low until reset", 80'(locked), 80'(0));

    // Phase 5 (R8 then R4/R5 again)
    doReset();
    q.delete();
    sbOn = 1'b1;
    base = 5;
    skew = '{2, 0, 1, 3};
    sendFrames(4);
    drain();
    check(locked == 1'b1, "R4 bonded after reset", 80'(locked), 80'(1));
    check(laneErr == 4'b0, "R8 error cleared", 80'(laneErr), 80'(0));

    finishRun();
  end
endmodule